// File: doc/BRIEF.md
# Coherency Unit Register Bank

This block is the memory-mapped register file of the coherency control unit in a small multicore cluster. It takes up a 256-byte address window on a simple strobe-based bus. Each access carries an access size of one, two or four bytes. Software uses the window to turn the unit on and off, to find out how many cores the cluster has, and to set a power state byte for each core.

The window holds three live items. The first is a one-bit enable register. The second is a read-only configuration word derived from the core-count parameter. The third is a 32-bit power status word, which can be read and written through four consecutive byte addresses. Every other offset reads as zero and drops writes, including those that would control invalidation, address filtering or access permissions on a full implementation. Read data is registered and holds until the next read.

Top module: `coh_ctrl_regs`

## Requirements
- R1: A write of valid size to offset 0x00 stores bus_wdata[0] as the enable bit. A read of 0x00 returns the enable bit in bit 0, with bits 31:1 zero.
- R2: A read of offset 0x04 returns ((2^NCORES - 1) << 4) | (NCORES - 1), where NCORES ranges from 1 to 4. Writes to 0x04 change nothing.
- R3: A read at offset 0x08+k, for k = 0..3, returns the power status word logically shifted right by 8*k bits.
- R4: A write at offset 0x08+k takes a mask M from bus_size, which gives the byte count: M is 0xFF for size 1, 0xFFFF for size 2 and 0xFFFFFFFF for size 4. The write replaces the word bits under (M << 8k), truncated to 32 bits, with ((bus_wdata & M) << 8k). All other bits keep their value.
- R5: A write whose bus_size is not 1, 2 or 4 changes neither the enable bit nor the power status word.
- R6: Every offset other than 0x00, 0x04 and 0x08..0x0B reads as zero and ignores writes. This includes 0x0C, 0x40, 0x44, 0x50 and 0x54.
- R7: A synchronous active-low reset clears the enable bit and bus_rdata. It leaves the power status word unchanged.
- R8: bus_rdata is updated on the clock edge that samples bus_rd and holds its value while bus_rd is low. A read and a write in the same cycle return the value from before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_addr | input | 8 | Byte offset within the window |
| bus_size | input | 3 | Access size in bytes (1, 2 or 4 are valid) |
| bus_wdata | input | 32 | Write data, right-aligned |
| bus_rdata | output | 32 | Registered read data |

## Verification
The embedded properties run on every cycle. They check that a lane write leaves all bits outside its shifted mask untouched and that the word is stable when no write targets it. They also check that bad-size writes leave the enable bit alone, that the configuration and unmapped offsets read back their fixed values, and that read data holds between reads. Some behaviours only the bench scenarios can show: that the power word survives a reset, that a read racing a write returns the older value, and that the merged word has the right contents after a chain of mixed-size writes at every lane offset. The bench shows these by sweeping all 256 offsets and every size code against an arithmetic model.

// File: rtl/coh_ctrl_pkg.sv
// Shared definitions for the coherency register bank: region codes and the
// access-size decoding. Assumes bus_size carries a byte count.
package coh_ctrl_pkg;

    localparam int ADDR_W = 8;
    localparam int DATA_W = 32;
    localparam int SIZE_W = 3;

    typedef enum logic [1:0] {
        RGN_NONE = 2'd0,
        RGN_CTRL = 2'd1,
        RGN_CFG  = 2'd2,
        RGN_PWR  = 2'd3
    } region_e;

    // Data mask for an access size; zero mask means the size is not legal.
    function automatic logic [DATA_W-1:0] size_mask(input logic [SIZE_W-1:0] sz);
        case (sz)
            3'd1:    return 32'h0000_00FF;
            3'd2:    return 32'h0000_FFFF;
            3'd4:    return 32'hFFFF_FFFF;
            default: return 32'h0000_0000;
        endcase
    endfunction

endpackage

// File: rtl/coh_ctrl_decode.sv
// Address decoder: classifies an 8-bit offset into a register region and
// extracts the byte lane for the power word. Purely combinational.
module coh_ctrl_decode
    import coh_ctrl_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    output region_e           region,
    output logic [1:0]        lane
);

    localparam logic [ADDR_W-1:0] OFF_CTRL = 8'h00;
    localparam logic [ADDR_W-1:0] OFF_CFG  = 8'h04;
    localparam logic [ADDR_W-3:0] PWR_BASE = 6'h02;

    // Region select: exact match for the single registers, word match for the power lanes.
    always_comb begin
        lane = addr[1:0];
        if (addr == OFF_CTRL)
            region = RGN_CTRL;
        else if (addr == OFF_CFG)
            region = RGN_CFG;
        else if (addr[ADDR_W-1:2] == PWR_BASE)
            region = RGN_PWR;
        else
            region = RGN_NONE;
    end

endmodule

// File: rtl/coh_ctrl_pwr.sv
// Power status word: 32 bits with a masked, lane-shifted merge on write.
// Assumes wr_en already includes the size-legality check. The word has no
// reset on purpose; it keeps its value through a reset.
module coh_ctrl_pwr
    import coh_ctrl_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        lane,
    input  logic [SIZE_W-1:0] size,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] word
);

    logic [DATA_W-1:0] base_mask;
    logic [DATA_W-1:0] lane_mask;
    logic [DATA_W-1:0] lane_data;
    logic [4:0]        shamt;

    // Build the shifted mask and the shifted, trimmed data.
    always_comb begin
        shamt     = {lane, 3'b000};
        base_mask = size_mask(size);
        lane_mask = base_mask << shamt;
        lane_data = (wdata & base_mask) << shamt;
    end

    // Merge the selected lanes into the stored word.
    always_ff @(posedge clk) begin
        if (wr_en)
            word <= (word & ~lane_mask) | lane_data;
    end

    // R4
    lane_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> ((word ^ $past(word)) & ~$past(lane_mask)) == '0);

    // R5
    pwr_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(word));

endmodule

// File: rtl/coh_ctrl_rdmux.sv
// Registered read path: picks the addressed value on a read strobe and holds
// it otherwise. Assumes the region and lane come from the decoder.
module coh_ctrl_rdmux
    import coh_ctrl_pkg::*;
#(
    parameter int NCORES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd,
    input  region_e           region,
    input  logic [1:0]        lane,
    input  logic              ctrl,
    input  logic [DATA_W-1:0] pwr_word,
    output logic [DATA_W-1:0] rdata
);

    localparam logic [DATA_W-1:0] CORE_MASK = (DATA_W'(1) << NCORES) - DATA_W'(1);
    localparam logic [DATA_W-1:0] CFG_VAL   = (CORE_MASK << 4) | DATA_W'(NCORES - 1);

    logic [DATA_W-1:0] sel;

    // Select the value for the addressed region.
    always_comb begin
        case (region)
            RGN_CTRL: sel = {{(DATA_W-1){1'b0}}, ctrl};
            RGN_CFG:  sel = CFG_VAL;
            RGN_PWR:  sel = pwr_word >> {lane, 3'b000};
            default:  sel = '0;
        endcase
    end

    // Capture on a read strobe, clear on reset.
    always_ff @(posedge clk) begin
        if (!rst_n)
            rdata <= '0;
        else if (rd)
            rdata <= sel;
    end

    // R2
    cfg_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && region == RGN_CFG) |=> rdata == CFG_VAL);

    // R6
    hole_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && region == RGN_NONE) |=> rdata == '0);

    // R8
    rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd |=> $stable(rdata));

endmodule

// File: rtl/coh_ctrl_regs.sv
// Top of the coherency register bank. Decodes the offset, keeps the enable
// bit, and connects the power word and the read path. Assumes single-cycle
// strobes and NCORES between 1 and 4.
module coh_ctrl_regs
    import coh_ctrl_pkg::*;
#(
    parameter int NCORES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [SIZE_W-1:0] bus_size,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata
);

    region_e           region;
    logic [1:0]        lane;
    logic              size_ok;
    logic              ctrl_we;
    logic              pwr_we;
    logic              ctrl_q;
    logic [DATA_W-1:0] pwr_word;

    coh_ctrl_decode i_decode (
        .addr   (bus_addr),
        .region (region),
        .lane   (lane)
    );

    // Qualify writes with a legal access size.
    always_comb begin
        size_ok = (size_mask(bus_size) != '0);
        ctrl_we = bus_wr && size_ok && (region == RGN_CTRL);
        pwr_we  = bus_wr && size_ok && (region == RGN_PWR);
    end

    // Enable bit: bit 0 only, cleared by reset.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ctrl_q <= 1'b0;
        else if (ctrl_we)
            ctrl_q <= bus_wdata[0];
    end

    coh_ctrl_pwr i_pwr (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (pwr_we),
        .lane  (lane),
        .size  (bus_size),
        .wdata (bus_wdata),
        .word  (pwr_word)
    );

    coh_ctrl_rdmux #(.NCORES(NCORES)) i_rdmux (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd       (bus_rd),
        .region   (region),
        .lane     (lane),
        .ctrl     (ctrl_q),
        .pwr_word (pwr_word),
        .rdata    (bus_rdata)
    );

    // R1
    ctrl_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == 8'h00 && (bus_size == 3'd1 || bus_size == 3'd2 || bus_size == 3'd4))
        |=> ctrl_q == $past(bus_wdata[0]));

    // R5
    bad_size_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && !(bus_size == 3'd1 || bus_size == 3'd2 || bus_size == 3'd4)) |=> $stable(ctrl_q));

endmodule

// File: tb/test_coh_ctrl_regs.sv
module test_coh_ctrl_regs;

    localparam int N = 2;
    localparam logic [31:0] CFG_EXP = (((32'd1 << N) - 32'd1) << 4) | 32'(N - 1);

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_rd = 1'b0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [2:0]  bus_size = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;

    int errors = 0;
    int checks = 0;
    logic        m_ctrl = 1'b0;
    logic [31:0] m_pwr = '0;
    logic [31:0] seed = 32'h1234_5678;

    always #4 clk = ~clk;

    coh_ctrl_regs #(.NCORES(N)) i_coh_ctrl_regs (
        .clk(clk), .rst_n(rst_n), .bus_rd(bus_rd), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_size(bus_size), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata)
    );

    function automatic logic [31:0] next_rand(input logic [31:0] s);
        logic [31:0] x = s;
        x = x ^ (x << 13);
        x = x ^ (x >> 17);
        x = x ^ (x << 5);
        return x;
    endfunction

    function automatic logic [31:0] mask_of(input logic [2:0] sz);
        if (sz == 3'd1) return 32'hFF;
        if (sz == 3'd2) return 32'hFFFF;
        if (sz == 3'd4) return 32'hFFFF_FFFF;
        return 32'h0;
    endfunction

    function automatic logic [31:0] exp_read(input logic [7:0] a);
        if (a == 8'h00) return {31'b0, m_ctrl};
        if (a == 8'h04) return CFG_EXP;
        if (a >= 8'h08 && a <= 8'h0B) return m_pwr >> (8 * (a - 8'h08));
        return 32'h0;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Model of a write as described by R1, R4, R5 and R6.
    task automatic model_write(input logic [7:0] a, input logic [2:0] sz, input logic [31:0] d);
        logic [31:0] m = mask_of(sz);
        if (m == 0) return;
        if (a == 8'h00) m_ctrl = d[0];
        else if (a >= 8'h08 && a <= 8'h0B) begin
            int sh = 8 * (a - 8'h08);
            m_pwr = (m_pwr & ~(m << sh)) | ((d & m) << sh);
        end
    endtask

    task automatic do_write(input logic [7:0] a, input logic [2:0] sz, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_size = sz; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
        model_write(a, sz, d);
    endtask

    task automatic do_read(input logic [7:0] a, input logic [2:0] sz, output logic [31:0] d);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a; bus_size = sz;
        @(negedge clk);
        bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    initial begin
        int cyc = 0;
        forever begin
            @(posedge clk);
            cyc++;
            if (cyc > 150000) begin
                errors++; checks++;
                $display("FAIL watchdog: actual=%0d expected<=150000", cyc);
                $display("Result: errors=%0d of %0d checks", errors, checks);
                $finish;
            end
        end
    end

    initial begin
        logic [31:0] r;
        logic [31:0] saved;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R7: reset state of read data, then control
        check("R7 rdata after reset", bus_rdata, 32'h0);
        do_read(8'h00, 3'd4, r);
        check("R7 ctrl after reset", r, 32'h0);

        // R2: configuration value and read-only behaviour
        do_read(8'h04, 3'd4, r);
        check("R2 config", r, CFG_EXP);
        do_write(8'h04, 3'd4, 32'hFFFF_FFFF);
        do_read(8'h04, 3'd4, r);
        check("R2 config after write", r, CFG_EXP);

        // R1: enable bit keeps only bit 0
        do_write(8'h00, 3'd4, 32'hFFFF_FFFE);
        do_read(8'h00, 3'd4, r);
        check("R1 ctrl bit0 clear", r, exp_read(8'h00));
        do_write(8'h00, 3'd1, 32'h0000_0003);
        do_read(8'h00, 3'd1, r);
        check("R1 ctrl bit0 set", r, exp_read(8'h00));

        // R4: full word, then R3 lane reads
        do_write(8'h08, 3'd4, 32'hA1B2_C3D4);
        for (int k = 0; k < 4; k++) begin
            do_read(8'(8 + k), 3'd1, r);
            check("R3 lane read", r, exp_read(8'(8 + k)));
        end

        // R4/R5: every lane with every size code
        for (int k = 0; k < 4; k++) begin
            for (int sz = 0; sz < 8; sz++) begin
                seed = next_rand(seed);
                do_write(8'(8 + k), 3'(sz), seed);
                do_read(8'h08, 3'd4, r);
                check((mask_of(3'(sz)) == 0) ? "R5 bad size" : "R4 lane write", r, m_pwr);
            end
        end

        // R5: bad size to control
        do_write(8'h00, 3'd3, 32'h0);
        do_read(8'h00, 3'd4, r);
        check("R5 ctrl bad size", r, 32'h1);

        // R6/R3: sweep all offsets for read values
        for (int a = 0; a < 256; a++) begin
            do_read(8'(a), 3'd4, r);
            check("R6 offset read", r, exp_read(8'(a)));
        end

        // R6: writes to every unmapped offset leave state alone
        saved = m_pwr;
        for (int a = 0; a < 256; a++) begin
            if (a != 0 && !(a >= 8 && a <= 11)) do_write(8'(a), 3'd4, 32'hFFFF_FFFF);
        end
        do_read(8'h08, 3'd4, r);
        check("R6 pwr kept", r, saved);
        do_read(8'h00, 3'd4, r);
        check("R6 ctrl kept", r, 32'h1);
        do_read(8'h0C, 3'd4, r);
        check("R6 invalidate reads zero", r, 32'h0);

        // R8: hold between reads, and read racing a write sees old value
        repeat (3) @(negedge clk);
        check("R8 rdata hold", bus_rdata, 32'h0);
        @(negedge clk);
        bus_rd = 1'b1; bus_wr = 1'b1; bus_addr = 8'h00; bus_size = 3'd4; bus_wdata = 32'h0;
        @(negedge clk);
        bus_rd = 1'b0; bus_wr = 1'b0;
        check("R8 read before write", bus_rdata, 32'h1);
        m_ctrl = 1'b0;
        do_read(8'h00, 3'd4, r);
        check("R8 write landed", r, 32'h0);

        // R7: reset clears control but keeps the power word
        do_write(8'h00, 3'd4, 32'h1);
        do_write(8'h08, 3'd4, 32'h5A5A_0FF0);
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        m_ctrl = 1'b0;
        check("R7 rdata cleared", bus_rdata, 32'h0);
        do_read(8'h00, 3'd4, r);
        check("R7 ctrl cleared", r, 32'h0);
        do_read(8'h08, 3'd4, r);
        check("R7 pwr kept", r, 32'h5A5A_0FF0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule